// File: doc/BRIEF.md
# Timed Sample Playback Sequencer

This block replays a table of timestamped output words. Upstream logic pushes samples into an internal first-in first-out buffer through a valid/ready handshake. Each sample holds a time value, a data word and an end-of-sequence marker bit. A start pulse clears a tick counter to zero and sets it running. The counter advances once every `TICK_DIV` core clocks. When the counter reaches the timestamp of the sample at the head of the buffer, the block drives that sample onto a registered parallel output bus. One bit of that bus is a strobe that changes state on every update, so downstream modules can spot each new word without a separate clock.

Four states control the block. The states are PB_IDLE (waiting after reset), PB_RUN (comparing the head timestamp with the counter), PB_GAP (a one-cycle spacer after each update) and PB_DONE (the sequence has ended). The transitions are:
- start: PB_IDLE or PB_DONE to PB_RUN, on a start pulse.
- emit: PB_RUN to PB_GAP, when a due sample is not a marker.
- resume: PB_GAP to PB_RUN, always after one cycle.
- finish: PB_RUN to PB_DONE, when a due sample is the marker.

Because of the spacer, the bus changes at most once every two clocks. A sample whose time has already passed is sent out at once and sets a sticky late flag. A tick that arrives while the buffer is empty sets a sticky underrun flag, and the bus keeps its last value.

Top module: `timed_playback`

## Requirements
- R1: After reset, `out_word` is 0, `busy`, `done`, `late_err` and `underrun` are 0, and `in_ready` is 1.
- R2: A sample is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while the buffer holds `DEPTH` samples.
- R3: A `start` pulse seen in PB_IDLE or PB_DONE clears the tick counter to 0, raises `busy`, and clears `done`, `late_err` and `underrun`. A `start` seen while `busy` is high has no effect on timing or flags.
- R4: The tick counter advances by one every `TICK_DIV` clocks while `busy`. Take edge 0 as the edge that captures `start`. A sample with timestamp T appears on `out_word` after edge `TICK_DIV*T+1`.
- R5: On each update, `out_word` carries the sample data, except that bit `STROBE_BIT` is replaced by the inverse of its previous value. The data bit at that position is discarded.
- R6: After each update, `out_word` holds for at least one further cycle. Two samples with the same timestamp therefore appear two clocks apart.
- R7: A head sample whose timestamp is lower than the counter is emitted at once and sets `late_err`. `late_err` stays set until the next accepted `start`.
- R8: A tick that occurs while `busy` with an empty buffer sets `underrun`, and `out_word` holds its value. `underrun` stays set until the next accepted `start`.
- R9: A sample with `in_last` = 1 is consumed at its timestamp without changing `out_word`. The block then enters PB_DONE, where `done` = 1 and `busy` = 0.
- R10: While `busy` is 0, `out_word` does not change, even when samples are pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run from idle or done |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Buffer has room |
| in_time | input | TIME_W | Sample timestamp in ticks |
| in_data | input | DATA_W | Sample output word |
| in_last | input | 1 | End-of-sequence marker |
| out_word | output | DATA_W | Registered output bus with embedded strobe |
| busy | output | 1 | Run in progress (PB_RUN or PB_GAP) |
| done | output | 1 | Sequence finished (PB_DONE) |
| late_err | output | 1 | Sticky: a sample was emitted after its time |
| underrun | output | 1 | Sticky: a tick passed with an empty buffer |

## Verification
The bound assertions check properties that must hold on every cycle:
- The strobe flips with every bus change (R5).
- There is one quiet cycle after each change (R6).
- `busy` and `done` are never high together.
- The bus stays frozen outside a run (R10).
- The late and underrun flags are sticky (R7, R8).

Exact arrival times can only be shown by the bench's scenarios. These include timestamp-to-edge latency, equal-timestamp spacing, the ignored mid-run start, the marker, backpressure at a full buffer, and late or underrun detection after a stalled feed. In each case the bench counts edges from the start pulse and compares against the tick arithmetic.

// File: rtl/pb_pkg.sv
package pb_pkg;

    typedef enum logic [1:0] {
        PB_IDLE = 2'd0,
        PB_RUN  = 2'd1,
        PB_GAP  = 2'd2,
        PB_DONE = 2'd3
    } pb_state_e;

endpackage

// File: rtl/pb_fifo.sv
module pb_fifo #(
    parameter int W     = 65,
    parameter int DEPTH = 512
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_word,
    input  logic         pop,
    output logic [W-1:0] head_word,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] cnt;
    logic          do_push;
    logic          do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head_word = mem[rd_ptr];

    function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= next_ptr(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= next_ptr(rd_ptr);
            end
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/pb_timebase.sv
module pb_timebase #(
    parameter int TIME_W   = 32,
    parameter int TICK_DIV = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              run,
    output logic              tick,
    output logic [TIME_W-1:0] now
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [PW-1:0] pre;

    generate
        if (TICK_DIV == 1) begin : g_nodiv
            assign tick = run;
        end else begin : g_div
            assign tick = run && (pre == PW'(TICK_DIV - 1));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre <= '0;
            now <= '0;
        end else if (clear) begin
            pre <= '0;
            now <= '0;
        end else if (run) begin
            if (tick) begin
                pre <= '0;
                now <= now + TIME_W'(1);
            end else begin
                pre <= pre + PW'(1);
            end
        end
    end

endmodule

// File: rtl/pb_sequencer.sv
module pb_sequencer
    import pb_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int TIME_W     = 32,
    parameter int STROBE_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              head_valid,
    input  logic [TIME_W-1:0] head_time,
    input  logic [DATA_W-1:0] head_data,
    input  logic              head_last,
    input  logic [TIME_W-1:0] now,
    input  logic              tick,
    output logic              pop,
    output logic              clear_time,
    output logic              busy,
    output logic              done,
    output logic              late_err,
    output logic              underrun,
    output logic [DATA_W-1:0] out_word
);
    pb_state_e state_q;
    pb_state_e state_d;

    logic due;
    logic behind;
    logic accept_start;
    logic emit;

    assign due          = head_valid && (head_time <= now);
    assign behind       = head_valid && (head_time < now);
    assign accept_start = start && ((state_q == PB_IDLE) || (state_q == PB_DONE));
    assign emit         = (state_q == PB_RUN) && due && !head_last;
    assign pop          = (state_q == PB_RUN) && due;
    assign clear_time   = accept_start;
    assign busy         = (state_q == PB_RUN) || (state_q == PB_GAP);
    assign done         = (state_q == PB_DONE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PB_IDLE: if (start) state_d = PB_RUN;
            PB_RUN: begin
                if (due) begin
                    state_d = head_last ? PB_DONE : PB_GAP;
                end
            end
            PB_GAP:  state_d = PB_RUN;
            PB_DONE: if (start) state_d = PB_RUN;
            default: state_d = PB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PB_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_word <= '0;
            late_err <= 1'b0;
            underrun <= 1'b0;
        end else begin
            if (emit) begin
                out_word             <= head_data;
                out_word[STROBE_BIT] <= ~out_word[STROBE_BIT];
            end
            if (accept_start) begin
                late_err <= 1'b0;
                underrun <= 1'b0;
            end else begin
                if ((state_q == PB_RUN) && behind) begin
                    late_err <= 1'b1;
                end
                if (busy && tick && !head_valid) begin
                    underrun <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/timed_playback.sv
module timed_playback #(
    parameter int DATA_W     = 32,
    parameter int TIME_W     = 32,
    parameter int DEPTH      = 512,
    parameter int TICK_DIV   = 100,
    parameter int STROBE_BIT = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [TIME_W-1:0] in_time,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic [DATA_W-1:0] out_word,
    output logic              busy,
    output logic              done,
    output logic              late_err,
    output logic              underrun
);
    localparam int FW = 1 + TIME_W + DATA_W;

    logic [FW-1:0]     head_word;
    logic              fifo_empty;
    logic              fifo_full;
    logic              pop;
    logic              clear_time;
    logic              tick;
    logic [TIME_W-1:0] now;

    assign in_ready = !fifo_full;

    pb_fifo #(
        .W     (FW),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (in_valid),
        .push_word ({in_last, in_time, in_data}),
        .pop       (pop),
        .head_word (head_word),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    pb_timebase #(
        .TIME_W   (TIME_W),
        .TICK_DIV (TICK_DIV)
    ) u_time (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear_time),
        .run   (busy),
        .tick  (tick),
        .now   (now)
    );

    pb_sequencer #(
        .DATA_W     (DATA_W),
        .TIME_W     (TIME_W),
        .STROBE_BIT (STROBE_BIT)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .head_valid (!fifo_empty),
        .head_time  (head_word[DATA_W +: TIME_W]),
        .head_data  (head_word[DATA_W-1:0]),
        .head_last  (head_word[FW-1]),
        .now        (now),
        .tick       (tick),
        .pop        (pop),
        .clear_time (clear_time),
        .busy       (busy),
        .done       (done),
        .late_err   (late_err),
        .underrun   (underrun),
        .out_word   (out_word)
    );

endmodule

// File: rtl/pb_checker.sv
module pb_checker #(
    parameter int DATA_W     = 32,
    parameter int STROBE_BIT = DATA_W - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [DATA_W-1:0] out_word,
    input logic              busy,
    input logic              done,
    input logic              late_err,
    input logic              underrun
);
    assert_strobe_flips_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_word) |-> (out_word[STROBE_BIT] != $past(out_word[STROBE_BIT])));

    assert_quiet_after_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_word) |=> $stable(out_word));

    assert_busy_done_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, done}));

    assert_frozen_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(out_word));

    assert_late_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (late_err && !start) |=> late_err);

    assert_underrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !start) |=> underrun);

    assert_underrun_in_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> $past(busy));

endmodule

bind timed_playback pb_checker #(
    .DATA_W     (DATA_W),
    .STROBE_BIT (STROBE_BIT)
) u_pb_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .out_word (out_word),
    .busy     (busy),
    .done     (done),
    .late_err (late_err),
    .underrun (underrun)
);

// File: tb/timed_playback_bench.sv
module timed_playback_bench;
    localparam int DW  = 32;
    localparam int TW  = 32;
    localparam int DIV = 4;
    localparam int DEP = 8;
    localparam int SB  = 31;
    localparam int NV  = 6;

    localparam logic [TW-1:0] T_TAB [NV] = '{32'd0, 32'd2, 32'd3, 32'd7, 32'd7, 32'd10};
    localparam logic [DW-1:0] D_TAB [NV] = '{32'h0000_00A1, 32'h8000_1234, 32'h7FFF_FFFF,
                                              32'h0000_0000, 32'h1234_5678, 32'hDEAD_BEEF};
    localparam logic          L_TAB [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
    localparam int            C_TAB [NV] = '{1, 9, 13, 29, 31, 41};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [TW-1:0] in_time = '0;
    logic [DW-1:0] in_data = '0;
    logic          in_last = 1'b0;
    logic [DW-1:0] out_word;
    logic          busy;
    logic          done;
    logic          late_err;
    logic          underrun;

    int  checks = 0;
    int  fails = 0;
    int  cyc = 0;
    int  n0 = 0;
    bit  finished = 1'b0;
    logic exp_sb = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    timed_playback #(
        .DATA_W     (DW),
        .TIME_W     (TW),
        .DEPTH      (DEP),
        .TICK_DIV   (DIV),
        .STROBE_BIT (SB)
    ) u_timed_playback (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_time  (in_time),
        .in_data  (in_data),
        .in_last  (in_last),
        .out_word (out_word),
        .busy     (busy),
        .done     (done),
        .late_err (late_err),
        .underrun (underrun)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [TW-1:0] t, input logic [DW-1:0] d, input logic l);
        @(negedge clk);
        in_valid = 1'b1;
        in_time  = t;
        in_data  = d;
        in_last  = l;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n0 = cyc;
    endtask

    task automatic wait_change(output int when);
        logic [DW-1:0] prev;
        int k;
        prev = out_word;
        k = 0;
        while (out_word == prev && k < 200) begin
            @(negedge clk);
            k++;
        end
        when = cyc - n0;
    endtask

    function automatic logic [DW-1:0] expect_word(input logic [DW-1:0] d, input logic s);
        logic [DW-1:0] w;
        w = d;
        w[SB] = s;
        return w;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R4 watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int when;
        logic [DW-1:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(out_word == '0, "R1 out_word", out_word, 0);
        chk({busy, done, late_err, underrun} == 4'b0, "R1 flags",
            {busy, done, late_err, underrun}, 0);
        chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);

        // Vector table walk: timing (R4), strobe (R5), equal stamps (R6), marker (R9)
        for (int i = 0; i < NV; i++) push(T_TAB[i], D_TAB[i], L_TAB[i]);
        pulse_start();
        chk(busy == 1'b1, "R3 busy after start", busy, 1);
        for (int i = 0; i < NV - 1; i++) begin
            wait_change(when);
            exp_sb = ~exp_sb;
            chk(when == C_TAB[i], "R4 R6 update edge", when, C_TAB[i]);
            chk(out_word == expect_word(D_TAB[i], exp_sb), "R5 out_word",
                out_word, expect_word(D_TAB[i], exp_sb));
            if (i == 2) begin
                // R3: start during a run must not restart the counter
                @(negedge clk);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        end
        held = out_word;
        when = 0;
        while (!done && when < 200) begin
            @(negedge clk);
            when++;
        end
        chk(cyc - n0 == C_TAB[NV-1], "R9 done edge", cyc - n0, C_TAB[NV-1]);
        chk(out_word == held, "R9 marker leaves bus", out_word, held);
        chk(busy == 1'b0, "R9 busy low in done", busy, 0);
        chk(late_err == 1'b0 && underrun == 1'b0, "R3 R7 no flags in clean run",
            {late_err, underrun}, 0);

        // Underrun then late sample (R8, R7)
        pulse_start();
        chk(done == 1'b0, "R3 done cleared", done, 0);
        repeat (6) @(negedge clk);
        chk(underrun == 1'b1, "R8 underrun set", underrun, 1);
        chk(out_word == held, "R8 bus held", out_word, held);
        repeat (14) @(negedge clk);
        push(32'd1, 32'h0BAD_F00D, 1'b0);
        wait_change(when);
        exp_sb = ~exp_sb;
        chk(out_word == expect_word(32'h0BAD_F00D, exp_sb), "R7 late sample emitted",
            out_word, expect_word(32'h0BAD_F00D, exp_sb));
        chk(late_err == 1'b1, "R7 late_err set", late_err, 1);
        push(32'd0, 32'h0, 1'b1);
        repeat (4) @(negedge clk);
        chk(done == 1'b1, "R9 done after late marker", done, 1);
        chk(late_err == 1'b1 && underrun == 1'b1, "R7 R8 sticky flags",
            {late_err, underrun}, 3);

        // New start clears sticky flags (R3)
        push(32'd0, 32'h0, 1'b1);
        pulse_start();
        chk(late_err == 1'b0 && underrun == 1'b0, "R3 flags cleared",
            {late_err, underrun}, 0);
        repeat (3) @(negedge clk);
        chk(done == 1'b1 && late_err == 1'b0, "R9 on-time marker", {done, late_err}, 2);

        // Backpressure (R2) and frozen bus while not busy (R10)
        held = out_word;
        for (int i = 0; i < DEP; i++) push(32'd100 + 32'(i), 32'h5555_0000 + 32'(i), 1'b0);
        chk(in_ready == 1'b0, "R2 in_ready low when full", in_ready, 0);
        chk(out_word == held, "R10 bus frozen while idle", out_word, held);
        repeat (10) @(negedge clk);
        chk(out_word == held && busy == 1'b0, "R10 still frozen", out_word, held);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule